// File: doc/BRIEF.md
# Banked Accumulator ALU Unit

This unit holds a bank of sixteen 16-bit accumulators and a 4-bit pointer that selects one of them as the working accumulator. Each accepted operation takes the working accumulator and a 16-bit source operand and can write a result back to that accumulator. The operations are load, add and subtract with and without carry, bitwise logic, one's and two's complement, arithmetic shifts by 1, 2 or 4 places, a logical right shift, rotates with and without the carry, nibble and byte exchange, and compare. A five-bit status register holds carry, zero, sign, equal and overflow. Each operation updates only the flags it is defined to touch.

A 2-bit stepping mode makes the pointer move up or down by one after every accepted operation. This lets a sequence of operations walk through the bank without separate pointer writes. The pointer and the mode can each be written directly through their own write strobes. The working accumulator and the flags are always visible on the outputs. Instruction decode and any multiply-accumulate path sit outside this unit.

Top module: `bacc_alu_unit`

## Requirements
- R1: A synchronous active-low reset clears all sixteen accumulators, the pointer, the stepping mode and all flags to zero.
- R2: `acc_out` always shows the accumulator selected by `ptr_out`. Code 0 (LOAD) copies `src` into it and leaves every flag unchanged.
- R3: Code 1 (ADD) and code 3 (SUB) ignore the carry flag. Code 2 (ADDC) adds the carry and code 4 (SUBB) subtracts it. Carry, which is `flags_out[0]`, becomes the unsigned carry-out for additions and the borrow for subtractions.
- R4: After codes 1–4, zero (`flags_out[1]`) is set when the result is 0, sign (`flags_out[2]`) equals result bit 15, and overflow (`flags_out[4]`) is set on signed overflow.
- R5: Code 5 (AND), 6 (OR), 7 (XOR), 8 (CPL, bitwise invert) and 9 (NEG, two's complement) write the result and update zero and sign. Carry and overflow keep their values.
- R6: Codes 10/11/12 shift left by 1/2/4 and fill with zeros. Codes 13/14/15 shift right by 1/2/4 and copy the sign bit in. Carry takes the last bit shifted out, zero and sign follow the result, and overflow is unchanged.
- R7: Code 16 (SR) shifts right by one, fills with zero and puts bit 0 into carry. Codes 17 (RR) and 19 (RL) rotate right and left by one within 16 bits and leave carry unchanged. Codes 18 (RRC) and 20 (RLC) rotate through the carry as a 17-bit ring. Zero and sign follow the result.
- R8: Code 21 (XCHN) swaps the two nibbles inside each byte. Code 22 (XCH) swaps the two bytes. Both update zero and sign only.
- R9: Code 23 (CMP) sets equal (`flags_out[3]`) when `src` equals the working accumulator and clears it otherwise. It leaves the accumulator and all other flags unchanged. No other code changes the equal flag.
- R10: Every operation accepted with a code from 0 to 23 acts on the accumulator selected before the step. After it, the pointer follows the mode: 2'b00 holds, 2'b01 adds one modulo 16, 2'b10 subtracts one modulo 16, and 2'b11 holds.
- R11: When a pointer write coincides with an operation, the operation uses the old pointer and the written value replaces the step. When a mode write coincides with an operation, the step uses the old mode.
- R12: With `op_valid` high, codes 24 to 31 change no accumulator, flag or pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation strobe for this cycle |
| op_code | input | 5 | Operation code |
| src | input | 16 | Source operand |
| ptr_wr | input | 1 | Pointer write strobe |
| ptr_wdata | input | 4 | New pointer value |
| mode_wr | input | 1 | Stepping mode write strobe |
| mode_wdata | input | 2 | New stepping mode |
| acc_out | output | 16 | Currently selected accumulator |
| ptr_out | output | 4 | Accumulator pointer |
| flags_out | output | 5 | {overflow, equal, sign, zero, carry} |

## Verification
The two functions that collide are the automatic pointer step that follows an operation and a direct pointer or mode write in the same cycle. The bench drives a load together with a pointer write while the mode is set to step up. It then checks that the written pointer value holds, and writes the old pointer back to show that the load landed on the previously selected accumulator. A load issued in the same cycle as a mode change is judged by the pointer moving in the old direction. A further operation then shows the new direction has taken effect.

// File: rtl/bacc_pkg.sv
`timescale 1ns/1ps
// Package: shared operation codes, stepping modes and the flag layout
// for the banked accumulator ALU unit.
package bacc_pkg;

    localparam int OP_W   = 5;
    localparam int FLAG_W = 5;
    localparam int MODE_W = 2;

    // Operation codes; codes above OP_CMP are not recognised.
    typedef enum logic [OP_W-1:0] {
        OP_LOAD = 5'd0,
        OP_ADD  = 5'd1,
        OP_ADDC = 5'd2,
        OP_SUB  = 5'd3,
        OP_SUBB = 5'd4,
        OP_AND  = 5'd5,
        OP_OR   = 5'd6,
        OP_XOR  = 5'd7,
        OP_CPL  = 5'd8,
        OP_NEG  = 5'd9,
        OP_SLA1 = 5'd10,
        OP_SLA2 = 5'd11,
        OP_SLA4 = 5'd12,
        OP_SRA1 = 5'd13,
        OP_SRA2 = 5'd14,
        OP_SRA4 = 5'd15,
        OP_SR   = 5'd16,
        OP_RR   = 5'd17,
        OP_RRC  = 5'd18,
        OP_RL   = 5'd19,
        OP_RLC  = 5'd20,
        OP_XCHN = 5'd21,
        OP_XCH  = 5'd22,
        OP_CMP  = 5'd23
    } bacc_op_e;

    // Pointer stepping modes.
    typedef enum logic [MODE_W-1:0] {
        STEP_HOLD  = 2'b00,
        STEP_UP    = 2'b01,
        STEP_DOWN  = 2'b10,
        STEP_HOLD3 = 2'b11
    } bacc_step_e;

    // Status flags; carry is bit 0.
    typedef struct packed {
        logic ov;
        logic eq;
        logic sg;
        logic zr;
        logic cy;
    } bacc_flags_t;

    // True for codes that the unit acts on.
    function automatic logic op_known(input logic [OP_W-1:0] code);
        return code <= OP_CMP;
    endfunction

endpackage

// File: rtl/bacc_bank.sv
`timescale 1ns/1ps
// Module: bacc_bank
// Bank of NUM_ACC accumulators with one write port and one read port.
// Assumes wr_sel and rd_sel are below NUM_ACC. Read is combinational.
module bacc_bank #(
    parameter int DATA_W  = 16,
    parameter int NUM_ACC = 16,
    localparam int SEL_W  = $clog2(NUM_ACC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] entry_q [NUM_ACC];

    for (genvar g = 0; g < NUM_ACC; g++) begin : g_entry
        // Hold one accumulator; load it when it is the write target.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entry_q[g] <= '0;
            end else if (wr_en && (wr_sel == SEL_W'(g))) begin
                entry_q[g] <= wr_data;
            end
        end
    end

    // Present the selected accumulator.
    always_comb begin
        rd_data = entry_q[rd_sel];
    end

endmodule

// File: rtl/bacc_alu.sv
`timescale 1ns/1ps
// Module: bacc_alu
// Combinational ALU: computes the result and the next flags of one
// operation from the working accumulator, the source and the present
// flags. Assumes DATA_W is a multiple of 8 so that nibble and byte
// exchanges are well formed.
module bacc_alu
    import bacc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] src,
    input  bacc_flags_t       flags_in,
    output logic [DATA_W-1:0] result,
    output logic              acc_wr,
    output bacc_flags_t       flags_next
);

    localparam int MSB      = DATA_W - 1;
    localparam int NUM_BYTE = DATA_W / 8;

    logic [DATA_W:0]   add_full;
    logic [DATA_W:0]   sub_full;
    logic              cin_add;
    logic              cin_sub;
    logic              add_ov;
    logic              sub_ov;
    logic [DATA_W-1:0] nib_sw;
    logic [DATA_W-1:0] byte_sw;
    logic              zs_upd;

    // Nibble exchange inside every byte.
    for (genvar b = 0; b < NUM_BYTE; b++) begin : g_nib
        assign nib_sw[8*b+7:8*b] = {acc[8*b+3:8*b], acc[8*b+7:8*b+4]};
    end

    // Byte order reversal (a plain byte swap at 16 bits).
    for (genvar b = 0; b < NUM_BYTE; b++) begin : g_byte
        assign byte_sw[8*b+7:8*b] = acc[8*(NUM_BYTE-1-b)+7:8*(NUM_BYTE-1-b)];
    end

    // Adder and subtractor with optional carry/borrow in.
    always_comb begin
        cin_add  = (op == OP_ADDC) ? flags_in.cy : 1'b0;
        cin_sub  = (op == OP_SUBB) ? flags_in.cy : 1'b0;
        add_full = {1'b0, acc} + {1'b0, src} + {{DATA_W{1'b0}}, cin_add};
        sub_full = {1'b0, acc} - {1'b0, src} - {{DATA_W{1'b0}}, cin_sub};
        add_ov   = (acc[MSB] == src[MSB]) && (add_full[MSB] != acc[MSB]);
        sub_ov   = (acc[MSB] != src[MSB]) && (sub_full[MSB] != acc[MSB]);
    end

    // Select the result and the flags that the operation touches.
    always_comb begin
        result     = acc;
        acc_wr     = 1'b1;
        zs_upd     = 1'b1;
        flags_next = flags_in;
        case (op)
            OP_LOAD: begin
                result = src;
                zs_upd = 1'b0;
            end
            OP_ADD, OP_ADDC: begin
                result        = add_full[MSB:0];
                flags_next.cy = add_full[DATA_W];
                flags_next.ov = add_ov;
            end
            OP_SUB, OP_SUBB: begin
                result        = sub_full[MSB:0];
                flags_next.cy = sub_full[DATA_W];
                flags_next.ov = sub_ov;
            end
            OP_AND:  result = acc & src;
            OP_OR:   result = acc | src;
            OP_XOR:  result = acc ^ src;
            OP_CPL:  result = ~acc;
            OP_NEG:  result = '0 - acc;
            OP_SLA1: begin
                result        = {acc[MSB-1:0], 1'b0};
                flags_next.cy = acc[MSB];
            end
            OP_SLA2: begin
                result        = {acc[MSB-2:0], 2'b00};
                flags_next.cy = acc[DATA_W-2];
            end
            OP_SLA4: begin
                result        = {acc[MSB-4:0], 4'b0000};
                flags_next.cy = acc[DATA_W-4];
            end
            OP_SRA1: begin
                result        = {acc[MSB], acc[MSB:1]};
                flags_next.cy = acc[0];
            end
            OP_SRA2: begin
                result        = {{2{acc[MSB]}}, acc[MSB:2]};
                flags_next.cy = acc[1];
            end
            OP_SRA4: begin
                result        = {{4{acc[MSB]}}, acc[MSB:4]};
                flags_next.cy = acc[3];
            end
            OP_SR: begin
                result        = {1'b0, acc[MSB:1]};
                flags_next.cy = acc[0];
            end
            OP_RR:   result = {acc[0], acc[MSB:1]};
            OP_RRC: begin
                result        = {flags_in.cy, acc[MSB:1]};
                flags_next.cy = acc[0];
            end
            OP_RL:   result = {acc[MSB-1:0], acc[MSB]};
            OP_RLC: begin
                result        = {acc[MSB-1:0], flags_in.cy};
                flags_next.cy = acc[MSB];
            end
            OP_XCHN: result = nib_sw;
            OP_XCH:  result = byte_sw;
            OP_CMP: begin
                acc_wr        = 1'b0;
                zs_upd        = 1'b0;
                flags_next.eq = (src == acc);
            end
            default: begin
                acc_wr = 1'b0;
                zs_upd = 1'b0;
            end
        endcase
        if (zs_upd) begin
            flags_next.zr = (result == '0);
            flags_next.sg = result[MSB];
        end
    end

endmodule

// File: rtl/bacc_ptr_ctl.sv
`timescale 1ns/1ps
// Module: bacc_ptr_ctl
// Accumulator pointer and its stepping mode. A direct pointer write
// overrides the step of the same cycle; the step always uses the mode
// held before any mode write of that cycle. Assumes ptr_wdata < NUM_ACC.
module bacc_ptr_ctl
    import bacc_pkg::*;
#(
    parameter int NUM_ACC = 16,
    localparam int SEL_W  = $clog2(NUM_ACC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              ptr_wr,
    input  logic [SEL_W-1:0]  ptr_wdata,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_wdata,
    output logic [SEL_W-1:0]  ptr,
    output logic [MODE_W-1:0] mode
);

    localparam logic [SEL_W-1:0] LAST = SEL_W'(NUM_ACC - 1);

    logic [SEL_W-1:0] ptr_step;

    // Neighbour of the pointer in the current mode, wrapping at the ends.
    always_comb begin
        ptr_step = ptr;
        case (mode)
            STEP_UP:   ptr_step = (ptr == LAST) ? '0 : ptr + 1'b1;
            STEP_DOWN: ptr_step = (ptr == '0) ? LAST : ptr - 1'b1;
            default:   ptr_step = ptr;
        endcase
    end

    // Pointer register: a write wins, otherwise step after an operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (ptr_wr) begin
            ptr <= ptr_wdata;
        end else if (step) begin
            ptr <= ptr_step;
        end
    end

    // Stepping mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= STEP_HOLD;
        end else if (mode_wr) begin
            mode <= mode_wdata;
        end
    end

endmodule

// File: rtl/bacc_alu_unit.sv
`timescale 1ns/1ps
// Module: bacc_alu_unit (top)
// Banked accumulator ALU: the ALU works on the accumulator selected by
// the pointer, writes the result back, keeps the status flags and steps
// the pointer after each recognised operation. Unrecognised codes are
// ignored. Assumes NUM_ACC is at least 2.
module bacc_alu_unit
    import bacc_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int NUM_ACC = 16,
    localparam int SEL_W  = $clog2(NUM_ACC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [OP_W-1:0]   op_code,
    input  logic [DATA_W-1:0] src,
    input  logic              ptr_wr,
    input  logic [SEL_W-1:0]  ptr_wdata,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_wdata,
    output logic [DATA_W-1:0] acc_out,
    output logic [SEL_W-1:0]  ptr_out,
    output logic [FLAG_W-1:0] flags_out
);

    logic [SEL_W-1:0]  ptr_q;
    logic [MODE_W-1:0] mode_q;
    logic [DATA_W-1:0] acc_cur;
    logic [DATA_W-1:0] alu_res;
    logic              alu_wr;
    logic              op_take;
    bacc_flags_t       flags_q;
    bacc_flags_t       flags_nx;

    // An operation is taken when strobed with a recognised code.
    always_comb begin
        op_take = op_valid && op_known(op_code);
    end

    bacc_bank #(
        .DATA_W  (DATA_W),
        .NUM_ACC (NUM_ACC)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (op_take && alu_wr),
        .wr_sel  (ptr_q),
        .wr_data (alu_res),
        .rd_sel  (ptr_q),
        .rd_data (acc_cur)
    );

    bacc_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .op         (op_code),
        .acc        (acc_cur),
        .src        (src),
        .flags_in   (flags_q),
        .result     (alu_res),
        .acc_wr     (alu_wr),
        .flags_next (flags_nx)
    );

    bacc_ptr_ctl #(
        .NUM_ACC (NUM_ACC)
    ) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (op_take),
        .ptr_wr     (ptr_wr),
        .ptr_wdata  (ptr_wdata),
        .mode_wr    (mode_wr),
        .mode_wdata (mode_wdata),
        .ptr        (ptr_q),
        .mode       (mode_q)
    );

    // Status flag register, updated by every taken operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (op_take) begin
            flags_q <= flags_nx;
        end
    end

    // Drive the outputs.
    always_comb begin
        acc_out   = acc_cur;
        ptr_out   = ptr_q;
        flags_out = flags_q;
    end

endmodule

// File: rtl/bacc_alu_unit_chk.sv
`timescale 1ns/1ps
// Module: bacc_alu_unit_chk
// Checker bound to bacc_alu_unit; observes ports plus the stepping mode.
module bacc_alu_unit_chk
    import bacc_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int NUM_ACC = 16,
    localparam int SEL_W  = $clog2(NUM_ACC)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [OP_W-1:0]   op_code,
    input logic [DATA_W-1:0] src,
    input logic              ptr_wr,
    input logic [SEL_W-1:0]  ptr_wdata,
    input logic              mode_wr,
    input logic [MODE_W-1:0] mode_cur,
    input logic [DATA_W-1:0] acc_out,
    input logic [SEL_W-1:0]  ptr_out,
    input logic [FLAG_W-1:0] flags_out
);

    localparam logic [SEL_W-1:0] LAST = SEL_W'(NUM_ACC - 1);

    logic taken;
    logic still;
    logic arith;

    always_comb begin
        taken = op_valid && (op_code <= OP_CMP);
        still = !ptr_wr && ((mode_cur == STEP_HOLD) || (mode_cur == STEP_HOLD3));
        arith = (op_code >= OP_ADD) && (op_code <= OP_SUBB);
    end

    AST_LOAD_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_LOAD) |=> $stable(flags_out)); // R2

    AST_ADD_NO_CARRY_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_ADD && still)
        |=> (acc_out == DATA_W'($past(acc_out) + $past(src)))); // R3

    AST_ZERO_SIGN_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && arith && still)
        |=> (flags_out[1] == (acc_out == '0)) && (flags_out[2] == acc_out[DATA_W-1])); // R4

    AST_CMP_ONLY_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_CMP && still)
        |=> $stable(acc_out) && (flags_out[2:0] == $past(flags_out[2:0]))
            && (flags_out[4] == $past(flags_out[4]))
            && (flags_out[3] == ($past(src) == $past(acc_out)))); // R9

    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && !ptr_wr && mode_cur == STEP_UP)
        |=> (ptr_out == (($past(ptr_out) == LAST) ? '0 : $past(ptr_out) + 1'b1))); // R10

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && !ptr_wr && mode_cur == STEP_DOWN)
        |=> (ptr_out == (($past(ptr_out) == '0) ? LAST : $past(ptr_out) - 1'b1))); // R10

    AST_PTR_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_wr |=> (ptr_out == $past(ptr_wdata))); // R11

    AST_UNKNOWN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code > OP_CMP && !ptr_wr)
        |=> $stable(ptr_out) && $stable(acc_out) && $stable(flags_out)); // R12

endmodule

bind bacc_alu_unit bacc_alu_unit_chk #(
    .DATA_W  (DATA_W),
    .NUM_ACC (NUM_ACC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .src       (src),
    .ptr_wr    (ptr_wr),
    .ptr_wdata (ptr_wdata),
    .mode_wr   (mode_wr),
    .mode_cur  (mode_q),
    .acc_out   (acc_out),
    .ptr_out   (ptr_out),
    .flags_out (flags_out)
);

// File: tb/bacc_alu_unit_bench.sv
`timescale 1ns/1ps
// Directed bench for bacc_alu_unit: one task per scenario.
module bacc_alu_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [4:0]  op_code = '0;
    logic [15:0] src = '0;
    logic        ptr_wr = 1'b0;
    logic [3:0]  ptr_wdata = '0;
    logic        mode_wr = 1'b0;
    logic [1:0]  mode_wdata = '0;
    logic [15:0] acc_out;
    logic [3:0]  ptr_out;
    logic [4:0]  flags_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    bacc_alu_unit u_bacc_alu_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_valid   (op_valid),
        .op_code    (op_code),
        .src        (src),
        .ptr_wr     (ptr_wr),
        .ptr_wdata  (ptr_wdata),
        .mode_wr    (mode_wr),
        .mode_wdata (mode_wdata),
        .acc_out    (acc_out),
        .ptr_out    (ptr_out),
        .flags_out  (flags_out)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    // Checks the working accumulator and the flags {OV,E,S,Z,C}.
    task automatic chk_af(input string req, input string what, input int acc_e, input int fl_e);
        chk(req, {what, " acc"}, int'(acc_out), acc_e);
        chk(req, {what, " flags"}, int'(flags_out), fl_e);
    endtask

    // Drives one cycle of inputs at a falling edge; returns one cycle later.
    task automatic drive(input logic v, input logic [4:0] c, input logic [15:0] s,
                         input logic pw, input logic [3:0] pd,
                         input logic mw, input logic [1:0] md);
        op_valid = v; op_code = c; src = s;
        ptr_wr = pw; ptr_wdata = pd; mode_wr = mw; mode_wdata = md;
        @(negedge clk);
        op_valid = 1'b0; ptr_wr = 1'b0; mode_wr = 1'b0;
    endtask

    task automatic op(input logic [4:0] c, input logic [15:0] s);
        drive(1'b1, c, s, 1'b0, 4'd0, 1'b0, 2'd0);
    endtask

    task automatic set_ptr(input logic [3:0] p);
        drive(1'b0, 5'd0, 16'h0, 1'b1, p, 1'b0, 2'd0);
    endtask

    task automatic set_mode(input logic [1:0] m);
        drive(1'b0, 5'd0, 16'h0, 1'b0, 4'd0, 1'b1, m);
    endtask

    task automatic t_reset;
        chk("R1", "ptr after reset", int'(ptr_out), 0);
        chk_af("R1", "after reset", 0, 0);
        set_ptr(4'd9);
        chk("R1", "A9 after reset", int'(acc_out), 0);
        set_ptr(4'd0);
    endtask

    task automatic t_load;
        op(5'd0, 16'h1234);
        chk_af("R2", "load", 16'h1234, 5'b00000);
    endtask

    task automatic t_arith;
        op(5'd0, 16'hFFFF); op(5'd1, 16'h0001);
        chk_af("R3", "ADD wrap", 16'h0000, 5'b00011);
        op(5'd1, 16'h0001);
        chk_af("R3", "ADD ignores carry", 16'h0001, 5'b00000);
        op(5'd0, 16'hFFFF); op(5'd1, 16'h0001); op(5'd2, 16'h0005);
        chk_af("R3", "ADDC uses carry", 16'h0006, 5'b00000);
        op(5'd0, 16'h0005); op(5'd3, 16'h0007);
        chk_af("R3", "SUB borrow", 16'hFFFE, 5'b00101);
        op(5'd0, 16'h0009); op(5'd3, 16'h0002);
        chk_af("R3", "SUB ignores carry", 16'h0007, 5'b00000);
        op(5'd0, 16'h0005); op(5'd3, 16'h0007); op(5'd4, 16'h0000);
        chk_af("R3", "SUBB uses carry", 16'hFFFD, 5'b00100);
        op(5'd0, 16'h7FFF); op(5'd1, 16'h0001);
        chk_af("R4", "ADD signed overflow", 16'h8000, 5'b10100);
        op(5'd0, 16'h8000); op(5'd3, 16'h0001);
        chk_af("R4", "SUB signed overflow", 16'h7FFF, 5'b10000);
    endtask

    task automatic t_logic;
        op(5'd0, 16'h7FFF); op(5'd1, 16'h0001); op(5'd5, 16'hFFFF);
        chk_af("R5", "AND keeps OV", 16'h8000, 5'b10100);
        op(5'd0, 16'hFFFF); op(5'd1, 16'h0001);
        op(5'd0, 16'h0F0F); op(5'd5, 16'h00FF);
        chk_af("R5", "AND keeps C", 16'h000F, 5'b00001);
        op(5'd6, 16'hF000);
        chk_af("R5", "OR", 16'hF00F, 5'b00101);
        op(5'd7, 16'hF00F);
        chk_af("R5", "XOR to zero", 16'h0000, 5'b00011);
        op(5'd8, 16'h0000);
        chk_af("R5", "CPL", 16'hFFFF, 5'b00101);
        op(5'd9, 16'h0000);
        chk_af("R5", "NEG", 16'h0001, 5'b00001);
    endtask

    task automatic t_shift;
        op(5'd0, 16'hC001); op(5'd10, 16'h0);
        chk_af("R6", "SLA1", 16'h8002, 5'b00101);
        op(5'd0, 16'h4001); op(5'd11, 16'h0);
        chk_af("R6", "SLA2", 16'h0004, 5'b00001);
        op(5'd0, 16'h0F00); op(5'd12, 16'h0);
        chk_af("R6", "SLA4", 16'hF000, 5'b00100);
        op(5'd0, 16'h8003); op(5'd13, 16'h0);
        chk_af("R6", "SRA1", 16'hC001, 5'b00101);
        op(5'd0, 16'h8002); op(5'd14, 16'h0);
        chk_af("R6", "SRA2", 16'hE000, 5'b00101);
        op(5'd0, 16'h7018); op(5'd15, 16'h0);
        chk_af("R6", "SRA4", 16'h0701, 5'b00001);
    endtask

    task automatic t_rotate;
        op(5'd0, 16'h8001); op(5'd16, 16'h0);
        chk_af("R7", "SR", 16'h4000, 5'b00001);
        op(5'd0, 16'h0002); op(5'd17, 16'h0);
        chk_af("R7", "RR keeps C", 16'h0001, 5'b00001);
        op(5'd0, 16'h0002); op(5'd18, 16'h0);
        chk_af("R7", "RRC", 16'h8001, 5'b00100);
        op(5'd0, 16'h8000); op(5'd19, 16'h0);
        chk_af("R7", "RL keeps C", 16'h0001, 5'b00000);
        op(5'd0, 16'h8000); op(5'd20, 16'h0);
        chk_af("R7", "RLC", 16'h0000, 5'b00011);
    endtask

    task automatic t_swap;
        op(5'd0, 16'h12AB); op(5'd21, 16'h0);
        chk_af("R8", "XCHN", 16'h21BA, 5'b00001);
        op(5'd22, 16'h0);
        chk_af("R8", "XCH", 16'hBA21, 5'b00101);
    endtask

    task automatic t_cmp;
        op(5'd0, 16'h5555); op(5'd23, 16'h5555);
        chk_af("R9", "CMP equal", 16'h5555, 5'b01101);
        op(5'd23, 16'h5554);
        chk_af("R9", "CMP unequal", 16'h5555, 5'b00101);
    endtask

    task automatic t_step;
        set_mode(2'b01);
        op(5'd0, 16'h1111);
        chk("R10", "up ptr", int'(ptr_out), 1);
        chk("R10", "up new acc", int'(acc_out), 0);
        op(5'd0, 16'h2222);
        set_mode(2'b10);
        op(5'd0, 16'h3333);
        chk("R10", "down ptr", int'(ptr_out), 1);
        chk("R10", "down sees A1", int'(acc_out), 16'h2222);
        op(5'd1, 16'h0001);
        chk("R10", "op before step", int'(acc_out), 16'h1111);
        op(5'd0, 16'h4444);
        chk("R10", "wrap below 0", int'(ptr_out), 15);
        set_mode(2'b01);
        op(5'd0, 16'h5555);
        chk("R10", "wrap above 15", int'(ptr_out), 0);
        chk("R10", "A0 after wrap", int'(acc_out), 16'h4444);
        set_ptr(4'd1);
        chk("R10", "ADD landed on A1", int'(acc_out), 16'h2223);
        set_ptr(4'd0);
        set_mode(2'b11);
        op(5'd0, 16'h6666);
        chk("R10", "mode 11 holds", int'(ptr_out), 0);
        chk("R10", "mode 11 acc", int'(acc_out), 16'h6666);
    endtask

    task automatic t_collide;
        set_mode(2'b01);
        set_ptr(4'd3);
        drive(1'b1, 5'd0, 16'hABCD, 1'b1, 4'd7, 1'b0, 2'd0);
        chk("R11", "ptr write beats step", int'(ptr_out), 7);
        set_ptr(4'd3);
        chk("R11", "op used old ptr", int'(acc_out), 16'hABCD);
        drive(1'b1, 5'd0, 16'h0707, 1'b0, 4'd0, 1'b1, 2'b10);
        chk("R11", "step used old mode", int'(ptr_out), 4);
        op(5'd0, 16'h0808);
        chk("R11", "new mode after", int'(ptr_out), 3);
        chk("R11", "A3 content", int'(acc_out), 16'h0707);
    endtask

    task automatic t_unknown;
        logic [15:0] a0;
        logic [4:0]  f0;
        logic [3:0]  p0;
        a0 = acc_out; f0 = flags_out; p0 = ptr_out;
        op(5'd24, 16'hFFFF);
        op(5'd31, 16'h0000);
        chk("R12", "unknown ptr", int'(ptr_out), int'(p0));
        chk_af("R12", "unknown", int'(a0), int'(f0));
        set_ptr(p0 + 4'd1);
        chk("R12", "neighbour untouched", int'(acc_out), 16'h0808);
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_load;
        t_arith;
        t_logic;
        t_shift;
        t_rotate;
        t_swap;
        t_cmp;
        t_step;
        t_collide;
        t_unknown;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #50000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule